// File: doc/BRIEF.md
# Oldest-Ready Issue Picker

This block chooses one instruction per cycle from a bank of issue-queue slots. Every slot presents a ready flag and an age stamp. The stamps are handed out in program order as instructions enter the queue, and a smaller stamp means an older instruction. The picker grants the oldest slot among those that are ready. A slot's physical position has no bearing on the choice, so entries may sit in the queue in any order.

Inside, a balanced binary tree of comparators reduces the (valid, age, index) triples to a single winner. A slot that is not ready enters the tree as invalid, which acts as an infinite age, so its stamp cannot matter. The winning index is decoded into a one-hot grant and registered. The registered result reaches the ports one clock after the inputs are sampled. A valid flag and its complement report whether any slot was ready.

Top module: `age_select_top`

## Requirements
- R1: The grant outputs reflect the `ready_i` and `age_i` values sampled at the previous rising clock edge, giving one cycle of latency. Inputs changed between edges do not alter the outputs until the next edge.
- R2: `grant_o` has at most one bit set. Bit i grants slot i.
- R3: A slot that was not ready in the sampled cycle is never granted.
- R4: Among the ready slots, the one with the smallest age stamp is granted, wherever it sits in the bank. The stamp of slot i is `age_i[i*AGE_W +: AGE_W]`.
- R5: When ready slots tie on the smallest age, the lowest-numbered of them is granted.
- R6: `grant_vld_o` is 1 exactly when at least one slot was ready in the sampled cycle, and `no_grant_o` is always its complement.
- R7: When no slot is ready, `grant_o` is all zeros, `grant_vld_o` is 0 and `no_grant_o` is 1.
- R8: While synchronous active-high `rst` is sampled high, the next edge sets `grant_o` to 0, `grant_vld_o` to 0 and `no_grant_o` to 1.
- R9: The age stamp of a slot that is not ready has no effect, even when it is 0.
- R10: Stamps compare as unsigned numbers with no wraparound. A slot whose stamp is all ones is still granted when it is the only ready slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ready_i | input | N | Per-slot ready flags |
| age_i | input | N*AGE_W | Per-slot age stamps, slot i in bits [i*AGE_W +: AGE_W] |
| grant_o | output | N | Registered one-hot grant |
| grant_vld_o | output | 1 | Registered: some slot was ready |
| no_grant_o | output | 1 | Registered: no slot was ready |

## Verification
On every cycle, the assertions check three things against the previous cycle's inputs. The grant has at most one bit set and agrees with both flags. Only slots that were ready are granted. For every pair of ready slots, the younger one, or the higher-numbered one on a tie, stays ungranted. The exact slot chosen can only be shown by the bench's scenarios and by its comparison with a linear-scan model. Those scenarios cover stamps in reverse slot order, a non-ready slot holding stamp 0, an all-ones stamp, and full ties. The bench alone also shows the single-cycle latency and the effect of reset asserted while slots are ready.

// File: rtl/age_select_pkg.sv
package age_select_pkg;

    localparam int DEF_SLOTS = 8;
    localparam int DEF_AGE_W = 6;

    // index width, at least one bit
    function automatic int idx_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // number of leaves after padding to a power of two
    function automatic int leaf_count(input int n);
        return 1 << idx_bits(n);
    endfunction

endpackage

// File: rtl/age_min_node.sv
module age_min_node #(
    parameter int AGE_W = 6,
    parameter int IDX_W = 3
) (
    input  logic             lo_vld,
    input  logic [AGE_W-1:0] lo_age,
    input  logic [IDX_W-1:0] lo_idx,
    input  logic             hi_vld,
    input  logic [AGE_W-1:0] hi_age,
    input  logic [IDX_W-1:0] hi_idx,
    output logic             win_vld,
    output logic [AGE_W-1:0] win_age,
    output logic [IDX_W-1:0] win_idx
);
    // the lower-index side wins ties, an invalid side acts as infinity
    logic take_lo;

    always_comb begin
        take_lo = lo_vld && (!hi_vld || (lo_age <= hi_age));
        win_vld = lo_vld || hi_vld;
        win_age = take_lo ? lo_age : hi_age;
        win_idx = take_lo ? lo_idx : hi_idx;
    end
endmodule

// File: rtl/age_min_tree.sv
module age_min_tree
    import age_select_pkg::*;
#(
    parameter int N     = DEF_SLOTS,
    parameter int AGE_W = DEF_AGE_W
) (
    input  logic [N-1:0]             ready,
    input  logic [N*AGE_W-1:0]       ages,
    output logic                     root_vld,
    output logic [idx_bits(N)-1:0]   root_idx
);
    localparam int IDX_W = idx_bits(N);
    localparam int LEAVES = leaf_count(N);
    localparam int NODES  = 2 * LEAVES - 1;

    logic             nd_vld [NODES];
    logic [AGE_W-1:0] nd_age [NODES];
    logic [IDX_W-1:0] nd_idx [NODES];

    // leaves in heap layout, padded leaves are never valid
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign nd_vld[LEAVES-1+i] = ready[i];
            assign nd_age[LEAVES-1+i] = ages[i*AGE_W +: AGE_W];
        end else begin : g_pad
            assign nd_vld[LEAVES-1+i] = 1'b0;
            assign nd_age[LEAVES-1+i] = '1;
        end
        assign nd_idx[LEAVES-1+i] = IDX_W'(i);
    end

    // internal comparators, left child holds the lower indices
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        age_min_node #(.AGE_W(AGE_W), .IDX_W(IDX_W)) u_node (
            .lo_vld (nd_vld[2*k+1]),
            .lo_age (nd_age[2*k+1]),
            .lo_idx (nd_idx[2*k+1]),
            .hi_vld (nd_vld[2*k+2]),
            .hi_age (nd_age[2*k+2]),
            .hi_idx (nd_idx[2*k+2]),
            .win_vld(nd_vld[k]),
            .win_age(nd_age[k]),
            .win_idx(nd_idx[k])
        );
    end

    assign root_vld = nd_vld[0];
    assign root_idx = nd_idx[0];
endmodule

// File: rtl/grant_decode.sv
module grant_decode #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             sel_vld,
    input  logic [IDX_W-1:0] sel_idx,
    output logic [N-1:0]     onehot
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign onehot[i] = sel_vld && (sel_idx == IDX_W'(i));
    end
endmodule

// File: rtl/age_select_top.sv
module age_select_top
    import age_select_pkg::*;
#(
    parameter int N     = DEF_SLOTS,
    parameter int AGE_W = DEF_AGE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       ready_i,
    input  logic [N*AGE_W-1:0] age_i,
    output logic [N-1:0]       grant_o,
    output logic               grant_vld_o,
    output logic               no_grant_o
);
    localparam int IDX_W = idx_bits(N);

    logic             root_vld;
    logic [IDX_W-1:0] root_idx;
    logic [N-1:0]     grant_nxt;

    age_min_tree #(.N(N), .AGE_W(AGE_W)) u_tree (
        .ready   (ready_i),
        .ages    (age_i),
        .root_vld(root_vld),
        .root_idx(root_idx)
    );

    grant_decode #(.N(N), .IDX_W(IDX_W)) u_dec (
        .sel_vld(root_vld),
        .sel_idx(root_idx),
        .onehot (grant_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_o     <= '0;
            grant_vld_o <= 1'b0;
            no_grant_o  <= 1'b1;
        end else begin
            grant_o     <= grant_nxt;
            grant_vld_o <= root_vld;
            no_grant_o  <= !root_vld;
        end
    end
endmodule

// File: rtl/age_select_chk.sv
module age_select_chk #(
    parameter int N     = 8,
    parameter int AGE_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic [N-1:0]       ready_i,
    input logic [N*AGE_W-1:0] age_i,
    input logic [N-1:0]       grant_o,
    input logic               grant_vld_o,
    input logic               no_grant_o
);
    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    assert_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (grant_vld_o == (grant_o != '0)) && (no_grant_o == !grant_vld_o));

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (ready_i == '0) |=> (grant_o == '0) && no_grant_o);

    assert_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (ready_i != '0) |=> grant_vld_o);

    for (genvar i = 0; i < N; i++) begin : g_slot
        assert_ready_only_R3: assert property (@(posedge clk) disable iff (rst)
            !ready_i[i] |=> !grant_o[i]);

        for (genvar j = 0; j < N; j++) begin : g_pair
            if (i != j) begin : g_ne
                // a strictly older ready slot keeps slot j from winning
                assert_oldest_R4: assert property (@(posedge clk) disable iff (rst)
                    (ready_i[i] && ready_i[j] &&
                     (age_i[i*AGE_W +: AGE_W] < age_i[j*AGE_W +: AGE_W]))
                    |=> !grant_o[j]);
            end
            if (i < j) begin : g_lt
                assert_tie_low_R5: assert property (@(posedge clk) disable iff (rst)
                    (ready_i[i] && ready_i[j] &&
                     (age_i[i*AGE_W +: AGE_W] == age_i[j*AGE_W +: AGE_W]))
                    |=> !grant_o[j]);
            end
        end
    end
endmodule

bind age_select_top age_select_chk #(.N(N), .AGE_W(AGE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ready_i    (ready_i),
    .age_i      (age_i),
    .grant_o    (grant_o),
    .grant_vld_o(grant_vld_o),
    .no_grant_o (no_grant_o)
);

// File: tb/age_select_top_test.sv
module age_select_top_test;
    localparam int N = 8;
    localparam int AW = 6;
    localparam int NV = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    ready_i = '0;
    logic [N*AW-1:0] age_i = '0;
    logic [N-1:0]    grant_o;
    logic            grant_vld_o;
    logic            no_grant_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    age_select_top #(.N(N), .AGE_W(AW)) uut (
        .clk(clk), .rst(rst), .ready_i(ready_i), .age_i(age_i),
        .grant_o(grant_o), .grant_vld_o(grant_vld_o), .no_grant_o(no_grant_o)
    );

    // {ready, age7..age0, expected grant}
    localparam logic [63:0] VEC [NV] = '{
        {8'h01, 6'd10,6'd10,6'd10,6'd10,6'd10,6'd10,6'd10,6'd10, 8'h01},
        {8'hff, 6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7,  8'h80},
        {8'hff, 6'd3, 6'd40,6'd30,6'd2, 6'd8, 6'd2, 6'd9, 6'd5,  8'h04},
        {8'ha0, 6'd12,6'd1, 6'd20,6'd0, 6'd0, 6'd0, 6'd0, 6'd0,  8'h80},
        {8'h00, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd8,  8'h00},
        {8'h40, 6'd0, 6'd63,6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0,  8'h40},
        {8'hff, 6'd33,6'd33,6'd33,6'd33,6'd33,6'd33,6'd33,6'd33, 8'h01},
        {8'h18, 6'd0, 6'd0, 6'd0, 6'd62,6'd63,6'd0, 6'd0, 6'd0,  8'h10}
    };

    function automatic logic [N-1:0] ref_pick(input logic [N-1:0] r,
                                              input logic [N*AW-1:0] a);
        logic [N-1:0] g = '0;
        int best = -1;
        for (int i = 0; i < N; i++) begin
            if (r[i] && (best < 0 || a[i*AW +: AW] < a[best*AW +: AW])) best = i;
        end
        if (best >= 0) g[best] = 1'b1;
        return g;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_flags(input string req, input logic any);
        check(req, {6'd0, grant_vld_o, no_grant_o}, {6'd0, any, !any});
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hace1;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 grant", grant_o, '0);
        check_flags("R8 flags", 1'b0);
        rst = 1'b0;

        // table walk: R2 R4 R5 R7 R9 R10
        for (int v = 0; v < NV; v++) begin
            ready_i = VEC[v][63:56];
            age_i   = VEC[v][55:8];
            @(negedge clk);
            check($sformatf("R4/R5/R9/R10 vec%0d", v), grant_o, VEC[v][7:0]);
            check_flags($sformatf("R6/R7 vec%0d", v), VEC[v][7:0] != 0);
            check($sformatf("model vec%0d", v), grant_o, ref_pick(ready_i, age_i));
        end

        // R1 latency: change inputs, output holds until the edge
        ready_i = 8'h00;
        @(negedge clk);
        ready_i = 8'h20;
        age_i = '0;
        #1;
        check("R1 before edge", grant_o, 8'h00);
        @(negedge clk);
        check("R1 after edge", grant_o, 8'h20);

        // R3 only ready slots, older non-ready slot ignored
        ready_i = 8'h02;
        age_i = {6'd0,6'd0,6'd0,6'd0,6'd0,6'd0,6'd50,6'd0};
        @(negedge clk);
        check("R3 R9 non-ready older", grant_o, 8'h02);

        // R8 reset while slots are ready
        ready_i = 8'hff;
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid reset", grant_o, 8'h00);
        check_flags("R8 mid flags", 1'b0);
        rst = 1'b0;

        // pseudo-random sweep against linear-scan model
        for (int t = 0; t < 300; t++) begin
            logic [N*AW-1:0] a;
            for (int i = 0; i < N; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                a[i*AW +: AW] = lfsr[AW-1:0] & ((t % 3 == 0) ? 6'h07 : 6'h3f);
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ready_i = lfsr[7:0];
            age_i = a;
            @(negedge clk);
            check("R4 R5 sweep", grant_o, ref_pick(ready_i, age_i));
            check_flags("R6 sweep", ready_i != 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule